// File: doc/BRIEF.md
# DRAM Access Timing Sequencer

This block turns single read and write requests from the CPU side into DRAM control waveforms. It drives the row strobe, the column strobe, a row/column address select with the multiplexed address, and two pairs of read/write strobes. One pair is dedicated to DRAM. The other pair is the generic bus pair. Requests that an area decoder marks as DRAM are sequenced. Every other request passes this block untouched.

A software-written setup register sets the timing. It holds a RAS-phase length, a CAS-phase length and a precharge length, each from one to four cycles. It also holds a page-retention enable. One set of settings serves every DRAM area. The sequencer records the row it opened and compares later requests against it.

In normal mode the row stays open only for a DRAM request that arrives in the cycle straight after the previous access completes. In page-retention mode the row stays open across idle and non-DRAM cycles until a request to a different row forces a precharge. Two resets are provided. The cold reset clears the setup register and closes the row. The hot reset closes the row and keeps the register contents.

Top module: `dram_seq`

## Requirements
- R1: The setup register holds the page-retention enable at bit 8, the precharge code at bits 7:6, the CAS code at bits 4:3 and the RAS code at bits 1:0. Bits 5 and 2 read as 0, and every other bit reads back as written.
- R2: Cold reset clears the setup register to 0. It also drives `ras_n`, `cas_n` and all strobes high and `req_ready` low.
- R3: Hot reset closes the row, so `ras_n` goes high and the sequencer returns to idle. The setup register keeps its value.
- R4: A 2-bit code k gives a phase of k+1 cycles. A DRAM request accepted with the row closed raises `req_ready` exactly RAS+CAS clock edges after it is presented.
- R5: `cas_n` is low for exactly CAS cycles per access. `req_ready` is high for a single cycle, the last cycle with `cas_n` low.
- R6: While `ras_n` is low and `cas_n` is high, `addr_sel` is 0 and `dram_addr` carries the row, which is `req_addr[17:8]`. While `cas_n` is low, `addr_sel` is 1 and `dram_addr` carries the column, `req_addr[7:0]` zero-extended.
- R7: In normal mode, a same-row DRAM request presented in the ready cycle completes as a page access, CAS+1 edges later. If no such request comes, the row closes: `ras_n` is high after the precharge.
- R8: With page retention on, the row stays open (`ras_n` low) through idle cycles. A same-row request made while the row is open completes CAS edges later.
- R9: A request to a different row while the row is open raises `ras_n` for precharge+1 cycles (precharge plus one idle cycle) before the new row opens. From a standing open row it completes 1+PRE+RAS+CAS edges later.
- R10: A request with `req_dram` low is ignored. It gets no `req_ready` and leaves `ras_n` unchanged.
- R11: During CAS, a read drives `dram_rd_n` and a write drives `dram_we_n` when page retention is on. When it is off, they drive `bus_rd_n` and `bus_wr_n` instead. At most one strobe is low at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_cold_n | input | 1 | Cold reset, active low, asynchronous: clears setup and sequencer |
| rst_hot_n | input | 1 | Hot reset, active low, asynchronous: sequencer only |
| cfg_we | input | 1 | Setup register write enable |
| cfg_wdata | input | 9 | Setup register write data |
| cfg_rdata | output | 9 | Setup register read data |
| req_valid | input | 1 | Request present, held until ready |
| req_dram | input | 1 | Request targets a DRAM area |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Request address, row in upper 10 bits, column in lower 8 |
| req_ready | output | 1 | One-cycle completion pulse |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| addr_sel | output | 1 | 0 = row on `dram_addr`, 1 = column |
| dram_addr | output | 10 | Multiplexed DRAM address |
| dram_rd_n | output | 1 | Dedicated DRAM read strobe |
| dram_we_n | output | 1 | Dedicated DRAM low-byte write enable |
| bus_rd_n | output | 1 | Generic read strobe |
| bus_wr_n | output | 1 | Generic write strobe |

## Verification
Every result has a fixed latency in clock edges counted from the edge after the request is driven. Completion from a closed row takes RAS+CAS edges. A page hit on a standing open row takes CAS edges, and a hit presented in the ready cycle takes CAS+1. A row miss takes 1+PRE+RAS+CAS edges, or one more when presented in the ready cycle. The bench drives and samples at falling edges and counts edges until `req_ready` appears. It compares that count against the figure computed from the programmed codes, and in the same cycles it counts `cas_n` low cycles, `ras_n` high cycles, address contents and strobe activity. Register readback and the reset effects are sampled one falling edge after the write or the reset edge.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

   localparam int FLD_W   = 2;
   localparam int CFG_W   = 9;
   localparam int SUCC_B  = 8;
   localparam int PRE_LO  = 6;
   localparam int CAS_LO  = 3;
   localparam int RAS_LO  = 0;
   localparam logic [CFG_W-1:0] CFG_MASK = 9'h1DB;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RAS,
      ST_CAS,
      ST_OPEN,
      ST_PRE
   } seq_state_e;

   typedef struct packed {
      logic             succ;
      logic [FLD_W-1:0] pre;
      logic [FLD_W-1:0] cas;
      logic [FLD_W-1:0] ras;
   } timing_t;

endpackage

// File: rtl/dram_timing_reg.sv
module dram_timing_reg
   import dram_seq_pkg::*;
(
   input  logic             clk,
   input  logic             rst_cold_n,
   input  logic             wr_en,
   input  logic [CFG_W-1:0] wr_data,
   output logic [CFG_W-1:0] rd_data,
   output timing_t          timing
);

   timing_t tq;

   // Only the cold reset touches this register; hot reset is not wired here.
   always_ff @(posedge clk or negedge rst_cold_n) begin
      if (!rst_cold_n) begin
         tq <= '0;
      end else if (wr_en) begin
         tq.succ <= wr_data[SUCC_B];
         tq.pre  <= wr_data[PRE_LO +: FLD_W];
         tq.cas  <= wr_data[CAS_LO +: FLD_W];
         tq.ras  <= wr_data[RAS_LO +: FLD_W];
      end
   end

   always_comb begin
      rd_data                   = '0;
      rd_data[SUCC_B]           = tq.succ;
      rd_data[PRE_LO +: FLD_W]  = tq.pre;
      rd_data[CAS_LO +: FLD_W]  = tq.cas;
      rd_data[RAS_LO +: FLD_W]  = tq.ras;
   end

   assign timing = tq;

   assert_readback_R1: assert property (@(posedge clk) disable iff (!rst_cold_n)
      wr_en |=> (rd_data == ($past(wr_data) & CFG_MASK)));

endmodule

// File: rtl/dram_row_track.sv
module dram_row_track #(
   parameter int ROW_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [ROW_W-1:0] row_in,
   output logic             hit
);

   logic [ROW_W-1:0] row_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     row_q <= '0;
      else if (load)  row_q <= row_in;
   end

   assign hit = (row_q == row_in);

endmodule

// File: rtl/dram_phase_fsm.sv
module dram_phase_fsm
   import dram_seq_pkg::*;
#(
   parameter int CNT_W = FLD_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic             hit,
   input  logic             succ,
   input  logic [CNT_W-1:0] ras_m1,
   input  logic [CNT_W-1:0] cas_m1,
   input  logic [CNT_W-1:0] pre_m1,
   output seq_state_e       state_o,
   output logic             last_o,
   output logic             load_row_o
);

   seq_state_e       st_q, st_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             last;

   assign last = (cnt_q == '0);

   always_comb begin
      st_d  = st_q;
      cnt_d = last ? cnt_q : cnt_q - 1'b1;
      unique case (st_q)
         ST_IDLE: if (go) begin
            st_d  = ST_RAS;
            cnt_d = ras_m1;
         end
         ST_RAS: if (last) begin
            st_d  = ST_CAS;
            cnt_d = cas_m1;
         end
         ST_CAS: if (last) begin
            st_d  = ST_OPEN;
            cnt_d = '0;
         end
         ST_OPEN: begin
            if (go && hit) begin
               st_d  = ST_CAS;
               cnt_d = cas_m1;
            end else if (go || !succ) begin
               st_d  = ST_PRE;
               cnt_d = pre_m1;
            end
         end
         ST_PRE: if (last) begin
            st_d  = ST_IDLE;
            cnt_d = '0;
         end
         default: begin
            st_d  = ST_IDLE;
            cnt_d = '0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         cnt_q <= '0;
      end else begin
         st_q  <= st_d;
         cnt_q <= cnt_d;
      end
   end

   assign state_o    = st_q;
   assign last_o     = last;
   assign load_row_o = (st_q == ST_IDLE) && go;

   assert_hold_open_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_OPEN && succ && !go) |=> (st_q == ST_OPEN));

   assert_hit_page_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_OPEN && go && hit) |=> (st_q == ST_CAS));

endmodule

// File: rtl/dram_seq.sv
module dram_seq
   import dram_seq_pkg::*;
#(
   parameter int ROW_W = 10,
   parameter int COL_W = 8
) (
   input  logic                     clk,
   input  logic                     rst_cold_n,
   input  logic                     rst_hot_n,
   input  logic                     cfg_we,
   input  logic [CFG_W-1:0]         cfg_wdata,
   output logic [CFG_W-1:0]         cfg_rdata,
   input  logic                     req_valid,
   input  logic                     req_dram,
   input  logic                     req_write,
   input  logic [ROW_W+COL_W-1:0]   req_addr,
   output logic                     req_ready,
   output logic                     ras_n,
   output logic                     cas_n,
   output logic                     addr_sel,
   output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dram_addr,
   output logic                     dram_rd_n,
   output logic                     dram_we_n,
   output logic                     bus_rd_n,
   output logic                     bus_wr_n
);

   localparam int ADDR_W = ROW_W + COL_W;
   localparam int MA_W   = (ROW_W > COL_W) ? ROW_W : COL_W;

   timing_t          tmg;
   seq_state_e       st;
   logic             seq_rst_n, go, hit, last, load_row;
   logic [ROW_W-1:0] row_f;
   logic [COL_W-1:0] col_f;
   logic [MA_W-1:0]  row_ext, col_ext;
   logic             rd_act, wr_act, row_on;

   assign seq_rst_n = rst_cold_n & rst_hot_n;
   assign go        = req_valid & req_dram;
   assign row_f     = req_addr[ADDR_W-1 -: ROW_W];
   assign col_f     = req_addr[COL_W-1:0];

   dram_timing_reg u_reg (
      .clk        (clk),
      .rst_cold_n (rst_cold_n),
      .wr_en      (cfg_we),
      .wr_data    (cfg_wdata),
      .rd_data    (cfg_rdata),
      .timing     (tmg)
   );

   dram_row_track #(.ROW_W(ROW_W)) u_row (
      .clk    (clk),
      .rst_n  (seq_rst_n),
      .load   (load_row),
      .row_in (row_f),
      .hit    (hit)
   );

   dram_phase_fsm #(.CNT_W(FLD_W)) u_fsm (
      .clk        (clk),
      .rst_n      (seq_rst_n),
      .go         (go),
      .hit        (hit),
      .succ       (tmg.succ),
      .ras_m1     (tmg.ras),
      .cas_m1     (tmg.cas),
      .pre_m1     (tmg.pre),
      .state_o    (st),
      .last_o     (last),
      .load_row_o (load_row)
   );

   // Pad the narrower of row/column to the multiplexed address width.
   generate
      if (ROW_W == COL_W) begin : g_pad_none
         assign row_ext = row_f;
         assign col_ext = col_f;
      end else if (ROW_W > COL_W) begin : g_pad_col
         assign row_ext = row_f;
         assign col_ext = {{(MA_W-COL_W){1'b0}}, col_f};
      end else begin : g_pad_row
         assign row_ext = {{(MA_W-ROW_W){1'b0}}, row_f};
         assign col_ext = col_f;
      end
   endgenerate

   assign row_on    = (st == ST_RAS) || (st == ST_CAS) || (st == ST_OPEN);
   assign ras_n     = !row_on;
   assign cas_n     = (st != ST_CAS);
   assign addr_sel  = (st == ST_CAS);
   assign dram_addr = addr_sel ? col_ext : row_ext;
   assign req_ready = (st == ST_CAS) && last;

   assign rd_act    = (st == ST_CAS) && !req_write;
   assign wr_act    = (st == ST_CAS) &&  req_write;
   assign dram_rd_n = !(rd_act &&  tmg.succ);
   assign dram_we_n = !(wr_act &&  tmg.succ);
   assign bus_rd_n  = !(rd_act && !tmg.succ);
   assign bus_wr_n  = !(wr_act && !tmg.succ);

   assert_ready_pulse_R5: assert property (@(posedge clk) disable iff (!seq_rst_n)
      req_ready |=> !req_ready);

   assert_miss_close_R9: assert property (@(posedge clk) disable iff (!seq_rst_n)
      (st == ST_OPEN && go && !hit) |=> ras_n);

   assert_cas_in_row_R6: assert property (@(posedge clk) disable iff (!seq_rst_n)
      !cas_n |-> (!ras_n && addr_sel));

   assert_strobe_single_R11: assert property (@(posedge clk) disable iff (!seq_rst_n)
      $onehot0({!dram_rd_n, !dram_we_n, !bus_rd_n, !bus_wr_n}));

endmodule

// File: tb/tb_dram_seq.sv
`timescale 1ns/1ps
module tb_dram_seq;

   logic        clk = 1'b0;
   logic        rst_cold_n, rst_hot_n;
   logic        cfg_we;
   logic [8:0]  cfg_wdata, cfg_rdata;
   logic        req_valid, req_dram, req_write;
   logic [17:0] req_addr;
   logic        req_ready, ras_n, cas_n, addr_sel;
   logic [9:0]  dram_addr;
   logic        dram_rd_n, dram_we_n, bus_rd_n, bus_wr_n;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   dram_seq dut (
      .clk(clk), .rst_cold_n(rst_cold_n), .rst_hot_n(rst_hot_n),
      .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .req_valid(req_valid), .req_dram(req_dram), .req_write(req_write),
      .req_addr(req_addr), .req_ready(req_ready), .ras_n(ras_n), .cas_n(cas_n),
      .addr_sel(addr_sel), .dram_addr(dram_addr), .dram_rd_n(dram_rd_n),
      .dram_we_n(dram_we_n), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n)
   );

   task automatic chk_eq(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic cfg_write(input logic [8:0] d);
      cfg_we = 1'b1; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   // Presents a DRAM request at the current falling edge and waits for ready.
   task automatic run_access(input bit wr, input logic [17:0] a, input int exp_n,
                             input int exp_cas, input int exp_hi, input bit ded,
                             input string tag);
      int  n = 0, cas_c = 0, hi = 0;
      bit  addr_ok = 1'b1;
      logic [3:0] seen = '0, exp_seen;
      req_valid = 1'b1; req_dram = 1'b1; req_write = wr; req_addr = a;
      do begin
         @(negedge clk);
         n++;
         if (!cas_n) begin
            cas_c++;
            if (!(addr_sel && dram_addr == {2'b00, a[7:0]})) addr_ok = 1'b0;
         end else if (!ras_n) begin
            if (addr_sel || dram_addr != a[17:8]) addr_ok = 1'b0;
         end
         if (ras_n) hi++;
         seen = seen | {!dram_rd_n, !dram_we_n, !bus_rd_n, !bus_wr_n};
      end while (!req_ready && n < 200);
      exp_seen = {ded && !wr, ded && wr, !ded && !wr, !ded && wr};
      chk_eq({tag, " R4 ready latency"}, n, exp_n);
      chk_eq({tag, " R5 cas cycles"}, cas_c, exp_cas);
      chk_eq({tag, " R9 ras high cycles"}, hi, exp_hi);
      chk_eq({tag, " R6 address mux"}, addr_ok, 1);
      chk_eq({tag, " R11 strobes"}, seen, exp_seen);
   endtask

   // Drops the request and waits; optionally requires the row to stay open.
   task automatic idle_wait(input int k, input bit keep_open, input string tag);
      int lost = 0, rdy = 0;
      req_valid = 1'b0;
      for (int i = 0; i < k; i++) begin
         @(negedge clk);
         if (ras_n) lost++;
         if (req_ready) rdy++;
      end
      if (keep_open) chk_eq({tag, " R8 row held"}, lost, 0);
      chk_eq({tag, " R5 no stray ready"}, rdy, 0);
   endtask

   task automatic t_reset;
      rst_cold_n = 1'b0; rst_hot_n = 1'b1;
      cfg_we = 1'b0; cfg_wdata = '0;
      req_valid = 1'b0; req_dram = 1'b0; req_write = 1'b0; req_addr = '0;
      repeat (3) @(negedge clk);
      rst_cold_n = 1'b1;
      @(negedge clk);
      chk_eq("R2 cfg after cold", cfg_rdata, 0);
      chk_eq("R2 ras_n after cold", ras_n, 1);
      chk_eq("R2 cas_n after cold", cas_n, 1);
      chk_eq("R2 ready after cold", req_ready, 0);
      chk_eq("R2 strobes after cold", {dram_rd_n, dram_we_n, bus_rd_n, bus_wr_n}, 15);
   endtask

   task automatic t_register;
      cfg_write(9'h1FF);
      chk_eq("R1 all ones", cfg_rdata, 9'h1DB);
      cfg_write(9'h0A5);
      chk_eq("R1 pattern", cfg_rdata, 9'h081);
      cfg_write(9'h000);
      chk_eq("R1 clear", cfg_rdata, 0);
   endtask

   task automatic t_normal_fast;
      // all codes 0: 1-cycle phases, generic strobes
      run_access(1'b0, 18'h2_5A3, 2, 1, 0, 1'b0, "R4 fast read");
      run_access(1'b1, 18'h2_5F0, 2, 1, 0, 1'b0, "R7 fast b2b hit");
      idle_wait(6, 1'b0, "R7 fast close");
      chk_eq("R7 row closed fast", ras_n, 1);
   endtask

   task automatic t_normal_slow;
      // RAS 3, CAS 2, PRE 4, normal mode
      cfg_write(9'h0CA);
      run_access(1'b1, 18'h0_C11, 5, 2, 0, 1'b0, "R4 slow write");
      run_access(1'b0, 18'h0_C22, 3, 2, 0, 1'b0, "R7 b2b hit");
      run_access(1'b0, 18'h1_D33, 11, 2, 5, 1'b0, "R9 b2b miss");
      idle_wait(10, 1'b0, "R7 slow close");
      chk_eq("R7 row closed slow", ras_n, 1);
      run_access(1'b0, 18'h1_D44, 5, 2, 0, 1'b0, "R7 same row not b2b");
      idle_wait(10, 1'b0, "R7 tail");
   endtask

   task automatic t_successive;
      int lost = 0, rdy = 0;
      // RAS 4, CAS 3, PRE 2, page retention on
      cfg_write(9'h153);
      run_access(1'b1, 18'h0_540, 7, 3, 0, 1'b1, "R4 succ write");
      idle_wait(6, 1'b1, "R8 succ idle");
      req_valid = 1'b1; req_dram = 1'b0; req_addr = 18'h3_FFF;
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         if (ras_n) lost++;
         if (req_ready) rdy++;
      end
      chk_eq("R10 ras unchanged", lost, 0);
      chk_eq("R10 no ready", rdy, 0);
      run_access(1'b0, 18'h0_577, 3, 3, 0, 1'b1, "R8 succ hit");
      idle_wait(3, 1'b1, "R8 succ gap");
      run_access(1'b0, 18'h2_488, 10, 3, 3, 1'b1, "R9 succ miss");
      idle_wait(4, 1'b1, "R8 after miss");
   endtask

   task automatic t_hot_cold;
      rst_hot_n = 1'b0;
      @(negedge clk);
      rst_hot_n = 1'b1;
      @(negedge clk);
      chk_eq("R3 ras_n after hot", ras_n, 1);
      chk_eq("R3 cfg kept", cfg_rdata, 9'h153);
      run_access(1'b0, 18'h2_401, 7, 3, 0, 1'b1, "R3 access after hot");
      req_valid = 1'b0;
      rst_cold_n = 1'b0;
      @(negedge clk);
      rst_cold_n = 1'b1;
      @(negedge clk);
      chk_eq("R2 cfg cleared", cfg_rdata, 0);
      chk_eq("R2 row closed", ras_n, 1);
   endtask

   initial begin
      t_reset();
      t_register();
      t_normal_fast();
      t_normal_slow();
      t_successive();
      t_hot_cold();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #200000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule